// File: doc/BRIEF.md
# Parallel Port Extended Control Register with Byte FIFO

This block is the host-facing extended control register of a parallel port. It holds a three-bit operating mode, a DMA enable and a sticky service bit. It owns a 16-byte FIFO that sits between the host and the peripheral side. The host reaches four slots through a small bus: the latched data register, the FIFO data port, the control register itself, and one unused slot. Reads are combinational. Writes take effect at the clock edge.

The mode decides what the FIFO does. It can be held empty, filled and drained by the host alone as a loopback test, drained towards the peripheral in the forward direction, or filled from the peripheral in the reverse direction. The mode also decides whether the data lines may be turned around, and whether reads of the data slot return the live line value. A separate output opens the configuration register window in the configuration mode.

The service bit watches one of three conditions: DMA terminal count, free space against a write threshold, or fill level against a read threshold. The DMA enable and the direction choose which one applies. When hardware sets the bit, a one-cycle interrupt pulse is produced. After that the bit stays set until software writes it to zero.

Top module: `pp_ext_ctrl`

## Requirements
- R1: After reset the mode is 000, DMA enable is 0, the service bit is 1, irq is 0 and the FIFO is empty, so the control register reads 0x05.
- R2: The control register (hostSel 2) holds mode in bits 7:5, DMA enable in bit 3 and the service bit in bit 2. Bit 1 is the full flag and bit 0 is the empty flag, and both are read-only. Bit 4 reads 0.
- R3: In mode 000 the FIFO is held empty and host writes to the FIFO slot (hostSel 1) are ignored. dataOutEn stays 1 whatever the direction. In every other mode dataOutEn is the inverse of dirReverse.
- R4: A read of the data slot (hostSel 0) returns lineData in mode 001. In all other modes it returns the last byte written to that slot.
- R5: Bytes leave the FIFO in the order they entered. fifoFull is 1 exactly when 16 bytes are held, and fifoEmpty is 1 exactly when none are held.
- R6: A push into a full FIFO and a pop from an empty FIFO are ignored, and the stored bytes and the count are unchanged.
- R7: In mode 110 the host may write and read the FIFO. periphValid stays 0 and periphPut is ignored.
- R8: In mode 010 with forward direction, periphValid and periphByte present the FIFO head and periphTake removes it. In mode 011 with reverse direction, periphPut stores periphIn and host reads of the FIFO slot remove bytes.
- R9: cfgAccessEn is 1 in mode 111 and 0 in every other mode.
- R10: With DMA enabled, a cleared service bit is set by a dmaTc strobe, and the thresholds have no effect.
- R11: With DMA disabled and forward direction, a cleared service bit is set once the free slots are at least wrThresh.
- R12: With DMA disabled and reverse direction, a cleared service bit is set once the stored bytes are at least rdThresh.
- R13: Once set, the service bit stays 1 until software writes 0. A software write of 1 sets it without an interrupt.
- R14: irq is high for exactly one cycle each time hardware sets the service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Slot select: 0 data, 1 FIFO, 2 control |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (pops on the FIFO slot) |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Host read data, combinational |
| dirReverse | input | 1 | Direction: 1 reverse (peripheral to host) |
| dmaTc | input | 1 | DMA terminal-count strobe |
| rdThresh | input | 5 | Read service threshold in bytes |
| wrThresh | input | 5 | Write service threshold in free slots |
| lineData | input | 8 | Live value of the data lines |
| dataOut | output | 8 | Latched data register towards the lines |
| dataOutEn | output | 1 | Data line drive enable |
| periphByte | output | 8 | FIFO head offered to the peripheral side |
| periphValid | output | 1 | periphByte is valid for a forward transfer |
| periphTake | input | 1 | Peripheral side consumes the head byte |
| periphPut | input | 1 | Peripheral side delivers a byte |
| periphIn | input | 8 | Byte delivered by the peripheral side |
| modeField | output | 3 | Current mode |
| cfgAccessEn | output | 1 | Configuration register window open |
| irq | output | 1 | Service interrupt pulse |
| fifoFull | output | 1 | FIFO full flag |
| fifoEmpty | output | 1 | FIFO empty flag |

## Verification
Host reads are combinational, so read data is sampled in the same cycle as the strobe, a little after it is driven. A write, push or pop shows on the flags, the control register and periphByte one edge after its strobe. The service bit and irq need one more edge after the condition holds. A threshold crossing caused by a push or pop therefore raises irq two edges after the strobe, and a dmaTc strobe raises it one edge after. The bench drives at falling edges and samples between edges. It counts irq high cycles at falling edges, so a pulse that is too long or too many pulses shows up as a wrong count.

// File: rtl/pp_ext_pkg.sv
`timescale 1ns/1ps
package pp_ext_pkg;
  typedef enum logic [2:0] {
    MODE_STD    = 3'b000,
    MODE_BIDIR  = 3'b001,
    MODE_FIFO   = 3'b010,
    MODE_ECP    = 3'b011,
    MODE_EPP    = 3'b100,
    MODE_RSVD   = 3'b101,
    MODE_TEST   = 3'b110,
    MODE_CONFIG = 3'b111
  } ppModeT;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_FIFO = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef struct packed {
    logic push;
    logic pushFromPeriph;
    logic pop;
    logic flush;
    logic dataWr;
  } fifoStrobeT;
endpackage

// File: rtl/pp_ext_fifo.sv
`timescale 1ns/1ps
module pp_ext_fifo
  import pp_ext_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobeT    stb,
  input  logic [DW-1:0] hostWData,
  input  logic [DW-1:0] periphIn,
  output logic [DW-1:0] headByte,
  output logic [DW-1:0] dataReg,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [DW-1:0] pushByte;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign pushByte = stb.pushFromPeriph ? periphIn : hostWData;

  always_ff @(posedge clk) begin
    if (stb.push && !stb.flush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          dataReg <= '0;
    else if (stb.dataWr) dataReg <= hostWData;
  end

  assign headByte = mem[rdPtr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
endmodule

// File: rtl/pp_ext_ctl.sv
`timescale 1ns/1ps
module pp_ext_ctl
  import pp_ext_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostSel,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [DW-1:0] hostWData,
  output logic [DW-1:0] hostRData,
  input  logic          dirReverse,
  input  logic          dmaTc,
  input  logic [CW-1:0] rdThresh,
  input  logic [CW-1:0] wrThresh,
  input  logic [DW-1:0] lineData,
  input  logic          periphTake,
  input  logic          periphPut,
  input  logic [DW-1:0] headByte,
  input  logic [DW-1:0] dataReg,
  input  logic [CW-1:0] count,
  input  logic          full,
  input  logic          empty,
  output fifoStrobeT    stb,
  output logic          dataOutEn,
  output logic          periphValid,
  output logic [2:0]    modeField,
  output logic          cfgAccessEn,
  output logic          irq
);
  ppModeT        mode;
  logic          dmaEn, svcBit;
  logic          fifoLive, xferLive;
  logic          hostPush, hostPop, periphPush, periphPop;
  logic          ctrlWr, svcSet;
  logic [CW-1:0] freeSlots;

  assign fifoLive = (mode != MODE_STD);
  assign xferLive = (mode == MODE_FIFO) || (mode == MODE_ECP);
  assign ctrlWr   = hostWr && (hostSel == SEL_CTRL);

  assign hostPush    = hostWr && (hostSel == SEL_FIFO) && fifoLive && !full;
  assign hostPop     = hostRd && (hostSel == SEL_FIFO) && fifoLive && !empty;
  assign periphValid = xferLive && !dirReverse && !empty;
  assign periphPush  = periphPut && xferLive && dirReverse && !full && !hostPush;
  assign periphPop   = periphTake && periphValid && !hostPop;

  always_comb begin
    stb.push           = hostPush || periphPush;
    stb.pushFromPeriph = periphPush;
    stb.pop            = hostPop || periphPop;
    stb.flush          = !fifoLive;
    stb.dataWr         = hostWr && (hostSel == SEL_DATA);
  end

  assign freeSlots = CW'(DEPTH) - count;

  always_comb begin
    if (dmaEn)           svcSet = dmaTc;
    else if (dirReverse) svcSet = (count >= rdThresh);
    else                 svcSet = (freeSlots >= wrThresh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode   <= MODE_STD;
      dmaEn  <= 1'b0;
      svcBit <= 1'b1;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctrlWr) begin
        mode   <= ppModeT'(hostWData[7:5]);
        dmaEn  <= hostWData[3];
        svcBit <= hostWData[2];
      end else if (!svcBit && svcSet) begin
        svcBit <= 1'b1;
        irq    <= 1'b1;
      end
    end
  end

  always_comb begin
    case (hostSel)
      SEL_DATA: hostRData = (mode == MODE_BIDIR) ? lineData : dataReg;
      SEL_FIFO: hostRData = headByte;
      SEL_CTRL: hostRData = {mode, 1'b0, dmaEn, svcBit, full, empty};
      default:  hostRData = '0;
    endcase
  end

  assign dataOutEn   = (mode == MODE_STD) ? 1'b1 : !dirReverse;
  assign modeField   = mode;
  assign cfgAccessEn = (mode == MODE_CONFIG);
endmodule

// File: rtl/pp_ext_ctrl.sv
`timescale 1ns/1ps
module pp_ext_ctrl
  import pp_ext_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostSel,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [DW-1:0] hostWData,
  output logic [DW-1:0] hostRData,
  input  logic          dirReverse,
  input  logic          dmaTc,
  input  logic [CW-1:0] rdThresh,
  input  logic [CW-1:0] wrThresh,
  input  logic [DW-1:0] lineData,
  output logic [DW-1:0] dataOut,
  output logic          dataOutEn,
  output logic [DW-1:0] periphByte,
  output logic          periphValid,
  input  logic          periphTake,
  input  logic          periphPut,
  input  logic [DW-1:0] periphIn,
  output logic [2:0]    modeField,
  output logic          cfgAccessEn,
  output logic          irq,
  output logic          fifoFull,
  output logic          fifoEmpty
);
  fifoStrobeT    stb;
  logic [DW-1:0] headByte;
  logic [CW-1:0] count;

  pp_ext_ctl #(.DEPTH(DEPTH), .DW(DW)) u_ctl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWData(hostWData), .hostRData(hostRData), .dirReverse(dirReverse),
    .dmaTc(dmaTc), .rdThresh(rdThresh), .wrThresh(wrThresh), .lineData(lineData),
    .periphTake(periphTake), .periphPut(periphPut), .headByte(headByte),
    .dataReg(dataOut), .count(count), .full(fifoFull), .empty(fifoEmpty),
    .stb(stb), .dataOutEn(dataOutEn), .periphValid(periphValid),
    .modeField(modeField), .cfgAccessEn(cfgAccessEn), .irq(irq)
  );

  pp_ext_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWData(hostWData), .periphIn(periphIn),
    .headByte(headByte), .dataReg(dataOut), .count(count),
    .full(fifoFull), .empty(fifoEmpty)
  );

  assign periphByte = headByte;
endmodule

// File: rtl/pp_ext_chk.sv
`timescale 1ns/1ps
module pp_ext_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeField,
  input logic       fifoFull,
  input logic       fifoEmpty,
  input logic       irq,
  input logic       dataOutEn,
  input logic       periphValid
);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  // R14
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R3
  std_held_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeField == 3'b000 && $past(modeField) == 3'b000) |-> fifoEmpty);

  // R3
  std_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeField == 3'b000) |-> dataOutEn);

  // R7
  test_no_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeField == 3'b110) |-> !periphValid);
endmodule

bind pp_ext_ctrl pp_ext_chk u_chk (
  .clk(clk), .rstN(rstN), .modeField(modeField), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .irq(irq), .dataOutEn(dataOutEn), .periphValid(periphValid)
);

// File: tb/pp_ext_ctrl_bench.sv
`timescale 1ns/1ps
module pp_ext_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWData = 8'd0;
  logic [7:0] hostRData;
  logic       dirReverse = 1'b0, dmaTc = 1'b0;
  logic [4:0] rdThresh = 5'd4, wrThresh = 5'd4;
  logic [7:0] lineData = 8'h33;
  logic [7:0] dataOut, periphByte, periphIn = 8'd0;
  logic       dataOutEn, periphValid, periphTake = 1'b0, periphPut = 1'b0;
  logic [2:0] modeField;
  logic       cfgAccessEn, irq, fifoFull, fifoEmpty;

  int checks = 0, errors = 0, irqSeen = 0;

  always #10 clk = ~clk;

  pp_ext_ctrl u_pp_ext_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWData(hostWData), .hostRData(hostRData), .dirReverse(dirReverse),
    .dmaTc(dmaTc), .rdThresh(rdThresh), .wrThresh(wrThresh), .lineData(lineData),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .periphByte(periphByte),
    .periphValid(periphValid), .periphTake(periphTake), .periphPut(periphPut),
    .periphIn(periphIn), .modeField(modeField), .cfgAccessEn(cfgAccessEn),
    .irq(irq), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  always @(negedge clk) if (rstN && irq) irqSeen++;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(logic [1:0] sel, logic [7:0] d);
    @(negedge clk); hostSel = sel; hostWData = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); hostSel = sel; hostRd = 1'b1;
    #2 d = hostRData;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic takeOne();
    @(negedge clk); periphTake = 1'b1;
    @(negedge clk); periphTake = 1'b0;
  endtask

  task automatic putOne(logic [7:0] d);
    @(negedge clk); periphIn = d; periphPut = 1'b1;
    @(negedge clk); periphPut = 1'b0;
  endtask

  task automatic tcPulse();
    @(negedge clk); dmaTc = 1'b1;
    @(negedge clk); dmaTc = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] r;
    hostRead(2'd2, r);
    check("R1 ctrl reg", r, 8'h05);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 empty", {7'd0, fifoEmpty}, 8'd1);
    check("R9 cfg closed", {7'd0, cfgAccessEn}, 8'd0);
  endtask

  task automatic testStdMode();
    logic [7:0] r;
    hostWrite(2'd2, 8'h04);
    hostWrite(2'd1, 8'hAA);
    check("R3 FIFO held empty", {7'd0, fifoEmpty}, 8'd1);
    dirReverse = 1'b1; #1;
    check("R3 drive kept", {7'd0, dataOutEn}, 8'd1);
    dirReverse = 1'b0;
    hostWrite(2'd0, 8'h5A);
    hostRead(2'd0, r);
    check("R4 latched read", r, 8'h5A);
  endtask

  task automatic testBidir();
    logic [7:0] r;
    hostWrite(2'd2, 8'h24);
    hostRead(2'd0, r);
    check("R4 live lines", r, 8'h33);
    dirReverse = 1'b1; #1;
    check("R3 turnaround", {7'd0, dataOutEn}, 8'd0);
    dirReverse = 1'b0;
  endtask

  task automatic testLoopback();
    logic [7:0] r;
    hostWrite(2'd2, 8'hC4);
    for (int i = 0; i < 16; i++) begin
      hostWrite(2'd1, 8'(i * 7 + 1));
      if (i == 14) check("R5 not full at 15", {7'd0, fifoFull}, 8'd0);
    end
    check("R5 full at 16", {7'd0, fifoFull}, 8'd1);
    check("R7 no periph valid", {7'd0, periphValid}, 8'd0);
    hostRead(2'd2, r);
    check("R2 full bit", r, 8'hC6);
    hostWrite(2'd1, 8'hEE);
    for (int i = 0; i < 16; i++) begin
      hostRead(2'd1, r);
      check("R5 R6 order", r, 8'(i * 7 + 1));
    end
    check("R5 empty again", {7'd0, fifoEmpty}, 8'd1);
    hostRead(2'd1, r);
    hostWrite(2'd1, 8'h11);
    hostRead(2'd1, r);
    check("R6 pop on empty ignored", r, 8'h11);
    hostWrite(2'd2, 8'hD7);
    hostRead(2'd2, r);
    check("R2 read-only bits", r, 8'hC5);
    dirReverse = 1'b1;
    putOne(8'h99);
    check("R7 periph put ignored", {7'd0, fifoEmpty}, 8'd1);
    dirReverse = 1'b0;
  endtask

  task automatic testForward();
    hostWrite(2'd2, 8'h44);
    hostWrite(2'd1, 8'h10); hostWrite(2'd1, 8'h20); hostWrite(2'd1, 8'h30);
    for (int i = 1; i <= 3; i++) begin
      check("R8 forward valid", {7'd0, periphValid}, 8'd1);
      check("R8 forward byte", periphByte, 8'(i * 16));
      takeOne();
    end
    check("R8 drained", {7'd0, fifoEmpty}, 8'd1);
    check("R9 cfg closed", {7'd0, cfgAccessEn}, 8'd0);
  endtask

  task automatic testReverse();
    logic [7:0] r;
    dirReverse = 1'b1;
    hostWrite(2'd2, 8'h64);
    putOne(8'hA1); putOne(8'hB2);
    hostRead(2'd1, r); check("R8 reverse first", r, 8'hA1);
    hostRead(2'd1, r); check("R8 reverse second", r, 8'hB2);
    dirReverse = 1'b0;
    hostWrite(2'd2, 8'hE4);
    check("R9 cfg open", {7'd0, cfgAccessEn}, 8'd1);
  endtask

  task automatic testSvcForward();
    logic [7:0] r;
    int base;
    wrThresh = 5'd8;
    hostWrite(2'd2, 8'h44);
    for (int i = 0; i < 10; i++) hostWrite(2'd1, 8'(i));
    base = irqSeen;
    hostWrite(2'd2, 8'h40);
    tick(3);
    check("R11 below threshold", 8'(irqSeen - base), 8'd0);
    takeOne(); takeOne();
    tick(2);
    check("R11 R14 one pulse", 8'(irqSeen - base), 8'd1);
    hostRead(2'd2, r);
    check("R11 service set", r, 8'h44);
    for (int i = 0; i < 8; i++) takeOne();
    tick(2);
    check("R13 sticky", 8'(irqSeen - base), 8'd1);
  endtask

  task automatic testSvcReverse();
    logic [7:0] r;
    int base;
    rdThresh = 5'd3;
    dirReverse = 1'b1;
    hostWrite(2'd2, 8'h64);
    base = irqSeen;
    hostWrite(2'd2, 8'h60);
    putOne(8'h01); putOne(8'h02);
    tick(2);
    check("R12 below threshold", 8'(irqSeen - base), 8'd0);
    putOne(8'h03);
    tick(2);
    check("R12 R14 one pulse", 8'(irqSeen - base), 8'd1);
    for (int i = 0; i < 3; i++) hostRead(2'd1, r);
    dirReverse = 1'b0;
  endtask

  task automatic testSvcDma();
    logic [7:0] r;
    int base;
    hostWrite(2'd2, 8'h4C);
    base = irqSeen;
    hostWrite(2'd2, 8'h48);
    tick(3);
    check("R10 thresholds ignored", 8'(irqSeen - base), 8'd0);
    tcPulse();
    tick(2);
    check("R10 R14 tc pulse", 8'(irqSeen - base), 8'd1);
    hostRead(2'd2, r);
    check("R10 service set", r, 8'h4D);
    hostWrite(2'd2, 8'h48);
    hostWrite(2'd2, 8'h4C);
    tick(2);
    check("R13 sw set no irq", 8'(irqSeen - base), 8'd1);
    tcPulse();
    tick(2);
    check("R13 set stays quiet", 8'(irqSeen - base), 8'd1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testStdMode();
    testBidir();
    testLoopback();
    testForward();
    testReverse();
    testSvcForward();
    testSvcReverse();
    testSvcDma();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule